// File: doc/BRIEF.md
# Banked Memory Window Address Expander

This block widens a 16-bit CPU address into a 19-bit physical address by opening up to two bank windows inside the 64 KB CPU space. Each window is given a size and a base address, and it has a bank register. When the CPU address falls inside a window, the upper physical address lines come from that window's bank register instead of from the CPU. The number of upper lines that are replaced depends on the window size. Outside every active window, the CPU's upper address bits pass straight through and the extra lines are zero. The address path is purely combinational, so the expanded address is valid in the same cycle as the CPU address.

The block has six expansion lines. Each line is brought out on a pin that carries either the address bit or a general-purpose output bit, as a mask register selects. The block also drives a flag for the internal-resource decoder. The flag reports whether an enabled on-chip ROM may answer at the current address. The ROM may answer outside the windows, and inside a window only in banks whose top three expansion bits are zero. Internal registers, RAM and EEPROM that lie under a window are not gated, so they answer in every bank.

The block is programmed through a simple register write port: write enable, a 3-bit register select and an 8-bit data word.

Top module: `bwx_top`

## Requirements
- R1: After reset, both windows are disabled, the pin mask is 0 and the general-purpose value is 0. As a result, `xa_pin` reads 0, `win_hit` reads 00, `rom_ok` reads 1, and `phys_addr[18:13]` equals {000, cpu_addr[15:13]}.
- R2: The size register is at select 0. Bits [1:0] belong to window 1 and bits [3:2] to window 2. The encoding is 0 = disabled, 1 = 8 KB, 2 = 16 KB and 3 = 32 KB. A disabled window never hits.
- R3: The base register is at select 1. Bits [2:0] hold window 1's base as address bits 15:13, and bits [6:4] hold window 2's base. A base that is not aligned is truncated to the size boundary: 8 KB compares bits 15:13 and 16 KB compares bits 15:14. For a 32 KB window, base values 0 to 1 place the window at 0x0000, values 2 to 3 place it at 0x4000, and values 4 to 7 place it at 0x8000.
- R4: When both windows cover an address, window 1 wins. `win_hit` is one-hot or zero: bit 0 means window 1 serves the access and bit 1 means window 2 serves it.
- R5: Inside a window, expansion lines xa[5:0] (physical bits 18:13) take the window's bank register. For 8 KB all six lines are replaced. For 16 KB lines 5 to 1 are replaced and line 0 keeps CPU bit 13. For 32 KB lines 5 to 2 are replaced and lines 1 to 0 keep CPU bits 14:13.
- R6: Outside every active window, xa[2:0] equals cpu_addr[15:13] and xa[5:3] equals 0.
- R7: `phys_addr` equals {xa, cpu_addr[12:0]}.
- R8: `rom_ok` is 1 outside the windows. Inside a window it is 1 only when xa[5:3] is 000.
- R9: The pin mask is at select 4 and the general-purpose value at select 5, both in bits [5:0]. Pin i drives xa[i] when mask bit i is 1, and general-purpose bit i when mask bit i is 0.
- R10: The bank registers are at select 2 (window 1) and select 3 (window 2), in bits [5:0]. A write takes effect on the clock edge after it is presented. Writes to selects 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address |
| phys_addr | output | 19 | Expanded physical address |
| xa_pin | output | 6 | Expansion pins after the address/general-purpose mask |
| win_hit | output | 2 | Window serving the access (bit 0 = window 1) |
| rom_ok | output | 1 | On-chip ROM may answer at this address |

## Verification
The address path is tried with single 8 KB, 16 KB and 32 KB windows at aligned, unaligned and out-of-range bases. Addresses just inside and just outside each window show whether the masked compare and the 32 KB placement rule are right. An 8 KB window nested inside a 32 KB window is probed in the shared region, in the region only the larger window covers, and outside both, which separates priority from plain hit detection. Bank values with and without zero upper bits tell the ROM gate apart from the window hit. Mixed pin masks show whether each pin's source is chosen line by line.

// File: rtl/bwx_pkg.sv
package bwx_pkg;
    localparam int NWIN = 2;   // windows, fixed by register layout
    localparam int HI_W = 3;   // CPU address lines a window may replace

    typedef enum logic [1:0] {
        WSZ_OFF = 2'd0,
        WSZ_8K  = 2'd1,
        WSZ_16K = 2'd2,
        WSZ_32K = 2'd3
    } win_size_e;

    typedef enum logic [2:0] {
        RA_SIZE  = 3'd0,
        RA_BASE  = 3'd1,
        RA_BANK1 = 3'd2,
        RA_BANK2 = 3'd3,
        RA_PMASK = 3'd4,
        RA_GPVAL = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/bwx_regs.sv
module bwx_regs
    import bwx_pkg::*;
#(
    parameter int XA_W = 6,
    parameter int DW   = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_addr,
    input  logic [DW-1:0]                 wr_data,
    output win_size_e [NWIN-1:0]          size_q,
    output logic [NWIN-1:0][HI_W-1:0]     base_q,
    output logic [NWIN-1:0][XA_W-1:0]     bank_q,
    output logic [XA_W-1:0]               pmask_q,
    output logic [XA_W-1:0]               gpval_q
);
    localparam int SZ_STRIDE = 2;
    localparam int BS_STRIDE = 4;

    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DW-1], wr_data[BS_STRIDE-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NWIN; w++) begin
                size_q[w] <= WSZ_OFF;
                base_q[w] <= '0;
                bank_q[w] <= '0;
            end
            pmask_q <= '0;
            gpval_q <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                RA_SIZE: for (int w = 0; w < NWIN; w++)
                    size_q[w] <= win_size_e'(wr_data[SZ_STRIDE*w +: 2]);
                RA_BASE: for (int w = 0; w < NWIN; w++)
                    base_q[w] <= wr_data[BS_STRIDE*w +: HI_W];
                RA_BANK1: bank_q[0] <= wr_data[XA_W-1:0];
                RA_BANK2: bank_q[1] <= wr_data[XA_W-1:0];
                RA_PMASK: pmask_q   <= wr_data[XA_W-1:0];
                RA_GPVAL: gpval_q   <= wr_data[XA_W-1:0];
                default: ;
            endcase
        end
    end

    AST_BANK1_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_BANK1) |=> (bank_q[0] == $past(wr_data[XA_W-1:0]))); // R10
    AST_UNUSED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[2:1] == 2'b11) |=> ($stable(bank_q) && $stable(pmask_q) && $stable(gpval_q))); // R10
endmodule

// File: rtl/bwx_win_dec.sv
module bwx_win_dec
    import bwx_pkg::*;
#(
    parameter int XA_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  win_size_e         size,
    input  logic [HI_W-1:0]   base,
    input  logic [XA_W-1:0]   bank,
    input  logic [HI_W-1:0]   cpu_hi,
    output logic              hit,
    output logic [XA_W-1:0]   xa
);
    logic [1:0] q16;      // CPU address in 16 KB units
    logic [1:0] b32;      // 32 KB window start in 16 KB units
    logic       in32;

    assign q16 = cpu_hi[HI_W-1:HI_W-2];

    always_comb begin
        b32  = base[HI_W-1] ? 2'd2 : {1'b0, base[HI_W-2]};
        in32 = (q16 == b32) || (q16 == b32 + 2'd1);
        hit  = 1'b0;
        xa   = bank;
        unique case (size)
            WSZ_OFF: begin
                hit = 1'b0;
            end
            WSZ_8K: begin
                hit = (cpu_hi == base);
                xa  = bank;
            end
            WSZ_16K: begin
                hit = (q16 == base[HI_W-1:HI_W-2]);
                xa  = {bank[XA_W-1:1], cpu_hi[0]};
            end
            WSZ_32K: begin
                hit = in32;
                xa  = {bank[XA_W-1:2], cpu_hi[1:0]};
            end
        endcase
    end

    AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (size == WSZ_OFF) |-> !hit); // R2
    AST_32K_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (size == WSZ_32K) |-> (xa[1:0] == cpu_hi[1:0])); // R5
    AST_32K_TOP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (size == WSZ_32K && base[HI_W-1] && cpu_hi[HI_W-1]) |-> hit); // R3
endmodule

// File: rtl/bwx_top.sv
module bwx_top
    import bwx_pkg::*;
#(
    parameter int CPU_AW = 16,
    parameter int XA_W   = 6,
    parameter int DW     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [2:0]               wr_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic [CPU_AW-1:0]        cpu_addr,
    output logic [CPU_AW+HI_W-1:0]   phys_addr,
    output logic [XA_W-1:0]          xa_pin,
    output logic [NWIN-1:0]          win_hit,
    output logic                     rom_ok
);
    localparam int LO_W  = CPU_AW - HI_W;
    localparam int TOP_W = XA_W - HI_W;

    win_size_e [NWIN-1:0]          size_q;
    logic [NWIN-1:0][HI_W-1:0]     base_q;
    logic [NWIN-1:0][XA_W-1:0]     bank_q;
    logic [XA_W-1:0]               pmask_q;
    logic [XA_W-1:0]               gpval_q;
    logic [NWIN-1:0]               w_hit;
    logic [NWIN-1:0][XA_W-1:0]     w_xa;
    logic [HI_W-1:0]               cpu_hi;
    logic [XA_W-1:0]               xa;

    assign cpu_hi = cpu_addr[CPU_AW-1:LO_W];

    bwx_regs #(.XA_W(XA_W), .DW(DW)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .size_q(size_q), .base_q(base_q),
        .bank_q(bank_q), .pmask_q(pmask_q), .gpval_q(gpval_q)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        bwx_win_dec #(.XA_W(XA_W)) i_dec (
            .clk(clk), .rst_n(rst_n), .size(size_q[w]), .base(base_q[w]),
            .bank(bank_q[w]), .cpu_hi(cpu_hi), .hit(w_hit[w]), .xa(w_xa[w])
        );
    end

    // lowest-numbered window wins
    always_comb begin
        win_hit = '0;
        xa      = {{TOP_W{1'b0}}, cpu_hi};
        for (int w = NWIN-1; w >= 0; w--) begin
            if (w_hit[w]) begin
                win_hit = '0;
                win_hit[w] = 1'b1;
                xa = w_xa[w];
            end
        end
    end

    assign phys_addr = {xa, cpu_addr[LO_W-1:0]};
    assign rom_ok    = ~|win_hit || (xa[XA_W-1:HI_W] == '0);

    for (genvar i = 0; i < XA_W; i++) begin : g_pin
        assign xa_pin[i] = pmask_q[i] ? xa[i] : gpval_q[i];
    end

    AST_WIN1_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        w_hit[0] |-> (win_hit == 2'b01 && phys_addr[CPU_AW+HI_W-1:LO_W] == w_xa[0])); // R4
    AST_OUTSIDE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (w_hit == '0) |-> (phys_addr[CPU_AW+HI_W-1:LO_W] == {{TOP_W{1'b0}}, cpu_addr[CPU_AW-1:LO_W]})); // R6
    AST_ROM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((w_hit != '0) && (phys_addr[CPU_AW+HI_W-1:CPU_AW] != '0)) |-> !rom_ok); // R8
    AST_LOW_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[LO_W-1:0] == cpu_addr[LO_W-1:0]); // R7
endmodule

// File: tb/test_bwx_top.sv
module test_bwx_top;
    localparam int CLK_P = 10;
    localparam int NV = 10;
    // size, base, bank1, bank2, addr, exp xa, exp hit, exp rom
    localparam logic [52:0] VEC [NV] = '{
        {8'h01, 8'h02, 6'h2A, 6'h15, 16'h4123, 6'h2A, 2'b01, 1'b0},
        {8'h01, 8'h02, 6'h2A, 6'h15, 16'h6000, 6'h03, 2'b00, 1'b1},
        {8'h02, 8'h03, 6'h2A, 6'h15, 16'h6001, 6'h2B, 2'b01, 1'b0},
        {8'h03, 8'h06, 6'h2A, 6'h15, 16'hC000, 6'h2A, 2'b01, 1'b0},
        {8'h03, 8'h02, 6'h2A, 6'h15, 16'hA000, 6'h29, 2'b01, 1'b0},
        {8'h03, 8'h02, 6'h2A, 6'h15, 16'h3FFF, 6'h01, 2'b00, 1'b1},
        {8'h0D, 8'h02, 6'h2A, 6'h15, 16'h4000, 6'h2A, 2'b01, 1'b0},
        {8'h0D, 8'h02, 6'h2A, 6'h15, 16'h2000, 6'h15, 2'b10, 1'b0},
        {8'h0D, 8'h02, 6'h2A, 6'h15, 16'h9000, 6'h04, 2'b00, 1'b1},
        {8'h04, 8'h70, 6'h2A, 6'h05, 16'hE000, 6'h05, 2'b10, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] cpu_addr = '0;
    logic [18:0] phys_addr;
    logic [5:0]  xa_pin;
    logic [1:0]  win_hit;
    logic        rom_ok;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    bwx_top i_bwx_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
        .xa_pin(xa_pin), .win_hit(win_hit), .rom_ok(rom_ok)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_P*200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        cpu_addr = 16'hA123;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pins", xa_pin, 6'h00);
        chk("R1 hit", win_hit, 2'b00);
        chk("R1 rom", rom_ok, 1'b1);
        chk("R1 xa", phys_addr[18:13], 6'h05);

        wr(3'd4, 8'h3F);
        for (int i = 0; i < NV; i++) begin
            logic [7:0] sz, bs; logic [5:0] b1, b2, ex; logic [15:0] ad;
            logic [1:0] eh; logic er;
            {sz, bs, b1, b2, ad, ex, eh, er} = VEC[i];
            wr(3'd0, sz); wr(3'd1, bs); wr(3'd2, {2'b0, b1}); wr(3'd3, {2'b0, b2});
            cpu_addr = ad;
            #1;
            chk($sformatf("R5/R6 xa vec%0d", i), phys_addr[18:13], ex);
            chk($sformatf("R9 pin vec%0d", i), xa_pin, ex);
            chk($sformatf("R3/R4 hit vec%0d", i), win_hit, eh);
            chk($sformatf("R8 rom vec%0d", i), rom_ok, er);
            chk($sformatf("R7 low vec%0d", i), phys_addr[12:0], ad[12:0]);
        end

        // R2 disabled window 1 with base on the address: no hit
        wr(3'd0, 8'h00); wr(3'd1, 8'h02);
        cpu_addr = 16'h4000; #1;
        chk("R2 disabled", win_hit, 2'b00);
        chk("R2 xa", phys_addr[18:13], 6'h02);

        // R9 mixed mask: lines 3..0 address, 5..4 general purpose
        wr(3'd0, 8'h01); wr(3'd2, 8'h2A);
        wr(3'd4, 8'h0F); wr(3'd5, 8'h15);
        cpu_addr = 16'h4000; #1;
        chk("R9 mixed pins", xa_pin, 6'h1A);

        // R10 write timing: bank change visible only after the edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h07;
        #1;
        chk("R10 before edge", phys_addr[18:13], 6'h2A);
        @(posedge clk); #1;
        chk("R10 after edge", phys_addr[18:13], 6'h07);
        @(negedge clk); wr_en = 1'b0;

        // R10 unused selects ignored
        wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        #1;
        chk("R10 sel6/7 xa", phys_addr[18:13], 6'h07);
        chk("R10 sel6/7 pins", xa_pin, 6'h17);
        chk("R10 sel6/7 hit", win_hit, 2'b01);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule